// File: doc/BRIEF.md
# Sixteen-bit ALU with registered condition flags

This block is the execute-stage arithmetic and logic unit of a small 16-bit processor. It computes a 16-bit result from two operands and a 5-bit operation code without any clock. The four condition flags that the operation would produce are offered on a combinational output. A four-bit flag register keeps the flags across instructions. The decode stage asserts a write enable for the instructions that are allowed to change that register.

The supported operations are add, subtract, bitwise AND, OR, XOR and complement, and logical shifts of the first operand by an immediate amount. Add and subtract derive carry and overflow from the sign bits of the two operands and of the result. They do not use the adder's carry-out, and subtract uses the same two equations as add. Logic and shift operations clear carry and overflow.

The register file, operand selection and immediate sign extension sit outside the block. A short immediate therefore reaches the second operand already widened to 16 bits.

Top module: `nzcv_alu`

## Requirements
- R1: Codes 5'b00101 and 5'b01101 both give result = (opa_i + opb_i) mod 2^16.
- R2: Code 5'b00001 gives result = (opa_i - opb_i) mod 2^16.
- R3: For codes 00101, 01101 and 00001 the next carry is (a15 & b15) | (~r15 & (a15 | b15)). Here a15 and b15 are the top bits of opa_i and opb_i, and r15 is the top bit of the result.
- R4: For the same three codes the next overflow is (a15 & b15 & ~r15) | (~a15 & ~b15 & r15).
- R5: Code 00111 gives opa_i & opb_i, 00110 gives opa_i | opb_i, and 00100 gives opa_i ^ opb_i. Code 00000 gives ~opa_i, and opb_i has no effect on it.
- R6: Code 01001 shifts opa_i left and code 01000 shifts it right, both logically, by shamt_i places with zero fill. Any amount of 16 or more yields 0.
- R7: flags_next_o is {N,Z,C,V}, with N at bit 3 and V at bit 0. For every recognised code, N equals result bit 15, and Z is 1 exactly when the 16-bit result is zero.
- R8: For the logic codes (00000, 00100, 00110, 00111) and the shift codes (01000, 01001), the next C and V are both 0.
- R9: On a rising clock edge with flag_we_i high, flags_o takes the value flags_next_o had before that edge. With flag_we_i low, flags_o does not change.
- R10: rst_n low clears flags_o to 4'b0000 at once, without waiting for a clock edge.
- R11: Any other code gives result 0, and flags_next_o then equals the current flags_o, so a write leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 5 | Operation code |
| opa_i | input | 16 | First operand, also the value that shifts move |
| opb_i | input | 16 | Second operand, with immediates already sign-extended |
| shamt_i | input | 5 | Shift distance for the shift codes |
| flag_we_i | input | 1 | Loads the flag register at the next edge |
| result_o | output | 16 | Combinational result |
| flags_next_o | output | 4 | Combinational next flags {N,Z,C,V} |
| flags_o | output | 4 | Registered flags {N,Z,C,V} |

## Verification
The assertions assume that op_i, the operands, shamt_i and flag_we_i are known and settled at each rising edge. They assume nothing about which codes arrive or in what order, so unrecognised codes are checked as well. The stimulus changes inputs only on the falling edge. It mixes directed sign-boundary cases, shift distances at and beyond the width, and pseudo-random codes drawn from both the recognised and the unrecognised set. The write enable toggles randomly, and reset is pulsed in the middle of the run.

// File: rtl/nzcv_alu_pkg.sv
package nzcv_alu_pkg;

    typedef enum logic [4:0] {
        OP_NOT  = 5'b00000,
        OP_SUB  = 5'b00001,
        OP_XOR  = 5'b00100,
        OP_ADD  = 5'b00101,
        OP_OR   = 5'b00110,
        OP_AND  = 5'b00111,
        OP_LSR  = 5'b01000,
        OP_LSL  = 5'b01001,
        OP_ADDI = 5'b01101
    } alu_op_e;

    typedef enum logic [1:0] {
        GRP_ARITH,
        GRP_LOGIC,
        GRP_SHIFT,
        GRP_NONE
    } op_grp_e;

    typedef enum logic [1:0] {
        BW_NOT,
        BW_AND,
        BW_OR,
        BW_XOR
    } bw_sel_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    function automatic op_grp_e op_group(input logic [4:0] op);
        case (op)
            OP_ADD, OP_ADDI, OP_SUB:        return GRP_ARITH;
            OP_NOT, OP_AND, OP_OR, OP_XOR:  return GRP_LOGIC;
            OP_LSL, OP_LSR:                 return GRP_SHIFT;
            default:                        return GRP_NONE;
        endcase
    endfunction

    function automatic bw_sel_e bw_select(input logic [4:0] op);
        case (op)
            OP_AND:  return BW_AND;
            OP_OR:   return BW_OR;
            OP_XOR:  return BW_XOR;
            default: return BW_NOT;
        endcase
    endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o,
    output logic         carry_o,
    output logic         ovf_o
);
    localparam int MSB = W - 1;

    logic sa, sb, sr;

    always_comb begin
        res_o = sub_i ? (a_i - b_i) : (a_i + b_i);
        sa    = a_i[MSB];
        sb    = b_i[MSB];
        sr    = res_o[MSB];
        // sign-bit based carry and overflow, identical for add and subtract
        carry_o = (sa & sb) | (~sr & (sa | sb));
        ovf_o   = (sa & sb & ~sr) | (~sa & ~sb & sr);
    end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import nzcv_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  bw_sel_e      sel_i,
    output logic [W-1:0] res_o
);
    always_comb begin
        unique case (sel_i)
            BW_AND:  res_o = a_i & b_i;
            BW_OR:   res_o = a_i | b_i;
            BW_XOR:  res_o = a_i ^ b_i;
            default: res_o = ~a_i;
        endcase
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int W   = 16,
    parameter int SHW = 5
) (
    input  logic [W-1:0]   a_i,
    input  logic [SHW-1:0] amt_i,
    input  logic           right_i,
    output logic [W-1:0]   res_o
);
    // one stage per amount bit; a stage whose step reaches W clears the word
    logic [W-1:0] stage [SHW+1];

    assign stage[0] = a_i;

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int STEP = 1 << k;
        if (STEP >= W) begin : g_wide
            assign stage[k+1] = amt_i[k] ? '0 : stage[k];
        end else begin : g_narrow
            assign stage[k+1] = !amt_i[k] ? stage[k]
                              : (right_i ? (stage[k] >> STEP) : (stage[k] << STEP));
        end
    end

    assign res_o = stage[SHW];
endmodule

// File: rtl/nzcv_alu.sv
module nzcv_alu
    import nzcv_alu_pkg::*;
#(
    parameter int W   = 16,
    parameter int OPW = 5,
    parameter int SHW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [OPW-1:0] op_i,
    input  logic [W-1:0]   opa_i,
    input  logic [W-1:0]   opb_i,
    input  logic [SHW-1:0] shamt_i,
    input  logic           flag_we_i,
    output logic [W-1:0]   result_o,
    output logic [3:0]     flags_next_o,
    output logic [3:0]     flags_o
);
    localparam int MSB = W - 1;

    typedef struct packed {
        logic [W-1:0] result;
        flags_t       flags;
    } alu_out_t;

    logic [W-1:0] ar_res, bw_res, sh_res;
    logic         ar_c, ar_v;
    op_grp_e      grp;
    alu_out_t     calc;
    flags_t       flags_d, flags_q;

    alu_arith #(.W(W)) i_arith (
        .a_i     (opa_i),
        .b_i     (opb_i),
        .sub_i   (op_i == OP_SUB),
        .res_o   (ar_res),
        .carry_o (ar_c),
        .ovf_o   (ar_v)
    );

    alu_bitwise #(.W(W)) i_bitwise (
        .a_i   (opa_i),
        .b_i   (opb_i),
        .sel_i (bw_select(op_i)),
        .res_o (bw_res)
    );

    alu_shifter #(.W(W), .SHW(SHW)) i_shifter (
        .a_i     (opa_i),
        .amt_i   (shamt_i),
        .right_i (op_i == OP_LSR),
        .res_o   (sh_res)
    );

    always_comb begin
        grp  = op_group(op_i);
        calc = '0;
        unique case (grp)
            GRP_ARITH: begin
                calc.result  = ar_res;
                calc.flags.c = ar_c;
                calc.flags.v = ar_v;
            end
            GRP_LOGIC: calc.result = bw_res;
            GRP_SHIFT: calc.result = sh_res;
            default:   calc.result = '0;
        endcase
        calc.flags.n = calc.result[MSB];
        calc.flags.z = ~|calc.result;
        if (grp == GRP_NONE) begin
            calc.flags = flags_q;
        end
        flags_d = flag_we_i ? calc.flags : flags_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign result_o     = calc.result;
    assign flags_next_o = calc.flags;
    assign flags_o      = flags_q;
endmodule

// File: rtl/nzcv_alu_checker.sv
module nzcv_alu_checker #(
    parameter int W   = 16,
    parameter int OPW = 5,
    parameter int SHW = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic [OPW-1:0] op_i,
    input logic [SHW-1:0] shamt_i,
    input logic           flag_we_i,
    input logic [W-1:0]   result_o,
    input logic [3:0]     flags_next_o,
    input logic [3:0]     flags_o
);
    logic is_arith, is_logic, is_shift, known;

    always_comb begin
        is_arith = (op_i == 5'b00101) || (op_i == 5'b01101) || (op_i == 5'b00001);
        is_logic = (op_i == 5'b00000) || (op_i == 5'b00100) ||
                   (op_i == 5'b00110) || (op_i == 5'b00111);
        is_shift = (op_i == 5'b01000) || (op_i == 5'b01001);
        known    = is_arith || is_logic || is_shift;
    end

    AST_N_FOLLOWS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        known |-> (flags_next_o[3] == result_o[W-1]));                                    // R7
    AST_Z_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        known |-> (flags_next_o[2] == (result_o == '0)));                                 // R7
    AST_CV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (is_logic || is_shift) |-> (flags_next_o[1:0] == 2'b00));                         // R8
    AST_WIDE_SHIFT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (is_shift && (shamt_i >= SHW'(W))) |-> (result_o == '0));                         // R6
    AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we_i |=> (flags_o == $past(flags_next_o)));                                  // R9
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we_i |=> $stable(flags_o));                                                 // R9
    AST_UNKNOWN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        !known |-> ((flags_next_o == flags_o) && (result_o == '0)));                      // R11
endmodule

bind nzcv_alu nzcv_alu_checker #(.W(W), .OPW(OPW), .SHW(SHW)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_i         (op_i),
    .shamt_i      (shamt_i),
    .flag_we_i    (flag_we_i),
    .result_o     (result_o),
    .flags_next_o (flags_next_o),
    .flags_o      (flags_o)
);

// File: tb/test_nzcv_alu.sv
module test_nzcv_alu;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic [4:0]  op;
    logic [15:0] a, b;
    logic [4:0]  sh;
    logic        we;
    logic [15:0] res;
    logic [3:0]  fnext, fq;

    int n_chk  = 0;
    int n_fail = 0;
    logic [3:0] m_flags;

    nzcv_alu i_nzcv_alu (
        .clk(clk), .rst_n(rst_n), .op_i(op), .opa_i(a), .opb_i(b),
        .shamt_i(sh), .flag_we_i(we), .result_o(res),
        .flags_next_o(fnext), .flags_o(fq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (op=%b a=%h b=%h sh=%0d)", tag, act, exp, op, a, b, sh);
        end
    endtask

    function automatic string tag_of(input logic [4:0] o);
        case (o)
            5'b00101, 5'b01101:                     return "R1";
            5'b00001:                               return "R2";
            5'b00000, 5'b00100, 5'b00110, 5'b00111: return "R5";
            5'b01000, 5'b01001:                     return "R6";
            default:                                return "R11";
        endcase
    endfunction

    // behavioural reference: {result, N, Z, C, V}
    function automatic logic [19:0] model(input logic [4:0] o, input logic [15:0] x,
                                          input logic [15:0] y, input logic [4:0] s,
                                          input logic [3:0] cur);
        int r;
        bit arith = 0, known = 1;
        bit c = 0, v = 0;
        case (o)
            5'b00101, 5'b01101: begin r = (int'(x) + int'(y)) % 65536; arith = 1; end
            5'b00001:           begin r = (int'(x) - int'(y) + 65536) % 65536; arith = 1; end
            5'b00111: r = int'(x & y);
            5'b00110: r = int'(x | y);
            5'b00100: r = int'(x ^ y);
            5'b00000: r = int'(~x);
            5'b01001: r = (s >= 16) ? 0 : ((int'(x) * (1 << s)) % 65536);
            5'b01000: r = (s >= 16) ? 0 : (int'(x) / (1 << s));
            default:  begin r = 0; known = 0; end
        endcase
        if (arith) begin
            bit a15 = x[15], b15 = y[15], r15 = r[15];
            c = (a15 && b15) || (!r15 && (a15 || b15));   // R3
            v = (a15 && b15 && !r15) || (!a15 && !b15 && r15); // R4
        end
        if (!known) return {r[15:0], cur};
        return {r[15:0], r[15], (r[15:0] == 16'h0), c, v};
    endfunction

    task automatic step(input logic [4:0] o, input logic [15:0] x, input logic [15:0] y,
                        input logic [4:0] s, input logic w);
        logic [19:0] e;
        @(negedge clk);
        op = o; a = x; b = y; sh = s; we = w;
        #1;
        e = model(o, x, y, s, m_flags);
        chk(tag_of(o), res, e[19:4]);
        chk("R7 N/Z", {14'h0, fnext[3:2]}, {14'h0, e[3:2]});
        if (o == 5'b00101 || o == 5'b01101 || o == 5'b00001) begin
            chk("R3 carry", {15'h0, fnext[1]}, {15'h0, e[1]});
            chk("R4 overflow", {15'h0, fnext[0]}, {15'h0, e[0]});
        end else begin
            chk(tag_of(o) == "R11" ? "R11 flags" : "R8 C/V", {14'h0, fnext[1:0]}, {14'h0, e[1:0]});
        end
        @(posedge clk);
        if (w) m_flags = e[3:0];
        #1;
        chk("R9 flag register", {12'h0, fq}, {12'h0, m_flags});
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [4:0] ops [11];
        ops = '{5'b00101, 5'b01101, 5'b00001, 5'b00111, 5'b00110, 5'b00100,
                5'b00000, 5'b01001, 5'b01000, 5'b10110, 5'b11111};
        rst_n = 1'b0; op = '0; a = '0; b = '0; sh = '0; we = 1'b0; m_flags = '0;
        repeat (3) @(negedge clk);
        chk("R10 reset value", {12'h0, fq}, 16'h0);
        rst_n = 1'b1;

        // R1 add boundaries
        step(5'b00101, 16'h7FFF, 16'h0001, 0, 1);   // overflow into sign
        step(5'b00101, 16'hFFFF, 16'h0001, 0, 1);   // wrap to zero, carry
        step(5'b01101, 16'h8000, 16'h8000, 0, 1);   // R3/R4 both negative
        step(5'b01101, 16'h0010, 16'hFFF0, 0, 1);
        // R2 subtract
        step(5'b00001, 16'h0005, 16'h0005, 0, 1);
        step(5'b00001, 16'h8000, 16'h0001, 0, 1);
        step(5'b00001, 16'h0000, 16'h0001, 0, 1);
        // R5 logic, NOT with two different second operands
        step(5'b00111, 16'hF0F0, 16'hFF00, 0, 1);
        step(5'b00110, 16'h0000, 16'h0000, 0, 1);
        step(5'b00100, 16'hAAAA, 16'hAAAA, 0, 1);
        step(5'b00000, 16'h00FF, 16'h1234, 0, 1);
        step(5'b00000, 16'h00FF, 16'hFFFF, 0, 1);
        // R6 shifts, including 15, 16 and 31
        step(5'b01001, 16'h0001, 16'h0, 15, 1);
        step(5'b01001, 16'hFFFF, 16'h0, 16, 1);
        step(5'b01000, 16'h8000, 16'h0, 15, 1);
        step(5'b01000, 16'hFFFF, 16'h0, 31, 1);
        // R9 hold with write enable low
        step(5'b00101, 16'h7FFF, 16'h7FFF, 0, 1);
        step(5'b00110, 16'h0000, 16'h0000, 0, 0);
        // R11 unrecognised codes with write enable high
        step(5'b10110, 16'h1234, 16'h5678, 0, 1);
        step(5'b11100, 16'hFFFF, 16'hFFFF, 3, 1);

        for (int i = 0; i < 400; i++) begin
            step(ops[$urandom_range(0, 10)], 16'($urandom), 16'($urandom),
                 5'($urandom), 1'($urandom));
        end

        // R10 asynchronous reset in mid-run
        step(5'b00101, 16'h8000, 16'h8000, 0, 1);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R10 async clear", {12'h0, fq}, 16'h0);
        m_flags = '0;
        @(negedge clk);
        rst_n = 1'b1;
        step(5'b00001, 16'h0001, 16'h0002, 0, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule